// File: doc/BRIEF.md
# Single-Channel Byte Transfer and Search Engine

The block moves bytes between two 16-bit address ports, called A and B, one byte at a time. A direction input picks which port is the source. For each byte the engine reads the source over a simple valid/ready bus. In transfer operation it then writes the byte to the other port. In search operation it compares the byte against a match value, ignoring the bit positions set in a mask. Each port has its own control byte. That byte selects memory or I/O space and sets how the address moves: it counts up, counts down, or stays where it is.

The engine has three operating modes: one byte per service, an unconditional loop, and a loop gated by a ready line. The ready line's active level is programmable. A byte counter closes the block at a programmable length. The end-of-block and match flags stop the engine. At the end of each service the engine can raise a one-cycle interrupt request. Its vector can carry the interrupt cause in bits 2:1. A load strobe copies the start addresses into the ports and clears the counter and both flags. The register inputs are held stable by surrounding logic that is not part of this block.

Top module: `dma_search_engine`

## Requirements
- R1: With cmd_i bit 0 (transfer) and bit 1 (search) both zero, the engine issues no bus access and the counter stays put.
- R2: A service starts only when enable_i is high, the end-of-block flag is clear and, with search on, the match flag is clear.
- R3: In modes 0 and 2 a service starts only when ready_i equals rdy_pol_i. Mode 1 ignores ready_i.
- R4: Mode 0 moves exactly one byte per service and returns to idle. Modes 1 and 2 keep moving bytes until end of block, a match (search on) or, in mode 2, a ready drop.
- R5: With a_is_src_i high, port A is read and port B written. With it low the roles swap, and each port keeps its own control byte.
- R6: Port control bit 3 selects I/O space (bus_io_o high). Bit 5 holds the address. Otherwise bit 4 set increments it after each byte and bit 4 clear decrements it.
- R7: A destination write (bus_we_o high, carrying the byte just read) happens only when cmd_i bit 0 is set. Search-only operation performs reads alone.
- R8: With search on, a byte matches when ((byte ^ match_i) & ~mask_i) == 0. A match sets match_o and ends the service after that byte.
- R9: When ready_i differs from rdy_pol_i after a byte has moved, outside mode 1, neither port address changes for that byte, the counter still increments, and the service ends.
- R10: The counter increments once per byte. End of block is set when the count wraps to zero, or when length_i is neither 0 nor 0xFFFF and the count exceeds length_i.
- R11: At the end of a service with int_en_i high, a match with int_ctl_i bit 0 gives cause 2, else end of block with int_ctl_i bit 1 gives cause 4. A nonzero cause pulses irq_o for one cycle.
- R12: With int_ctl_i bit 5 set, irq_vec_o is (vec_base_i & 0xF9) + cause; with it clear irq_vec_o equals vec_base_i.
- R13: A load_i pulse loads both port addresses from their start inputs and clears the counter, end-of-block and match flags.
- R14: A bus request holds its address, direction and space stable until bus_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load start addresses, clear counter and flags |
| enable_i | input | 1 | Engine enable |
| cmd_i | input | 2 | Bit 0 transfer, bit 1 search |
| mode_i | input | 2 | 0 single byte, 1 free loop, 2 ready-gated loop |
| a_is_src_i | input | 1 | Port A is source when high |
| ctl_a_i | input | 8 | Port A control byte |
| ctl_b_i | input | 8 | Port B control byte |
| start_a_i | input | 16 | Port A start address |
| start_b_i | input | 16 | Port B start address |
| length_i | input | 16 | Block length |
| match_i | input | 8 | Search match byte |
| mask_i | input | 8 | Search don't-care mask |
| ready_i | input | 1 | External ready line |
| rdy_pol_i | input | 1 | Active level of ready_i |
| int_en_i | input | 1 | Interrupt enable |
| int_ctl_i | input | 8 | Interrupt control byte |
| vec_base_i | input | 8 | Base interrupt vector |
| bus_req_o | output | 1 | Bus access valid |
| bus_we_o | output | 1 | Access is a write |
| bus_io_o | output | 1 | Access targets I/O space |
| bus_addr_o | output | 16 | Access address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data |
| bus_ack_i | input | 1 | Access complete |
| addr_a_o | output | 16 | Current port A address |
| addr_b_o | output | 16 | Current port B address |
| byte_cnt_o | output | 16 | Byte counter |
| eob_o | output | 1 | End-of-block flag |
| match_o | output | 1 | Match flag |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vec_o | output | 8 | Interrupt vector |
| busy_o | output | 1 | Engine not idle |

## Verification
The assertions take cmd_i, mode_i, the control bytes and the interrupt inputs to be steady while a service runs. They also assume that bus_ack_i comes only while a request is up. The bench changes configuration only while enable_i is low and the engine is idle. Its slave acknowledges a request once, one cycle after it appears, so those assumptions hold. The one mid-run change is ready_i, which is dropped right after a chosen read completes. That places the change inside a byte's update.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_UPDATE, ST_CHECK
  } dma_state_e;

  localparam int CTL_IO  = 3;
  localparam int CTL_INC = 4;
  localparam int CTL_FIX = 5;

  localparam int CMD_XFER   = 0;
  localparam int CMD_SEARCH = 1;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_FREE   = 2'd1;

  localparam int ICTL_MATCH = 0;
  localparam int ICTL_EOB   = 1;
  localparam int ICTL_VSTAT = 5;
endpackage

// File: rtl/dma_port_addr.sv
module dma_port_addr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          step_i,
  input  logic          fixed_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_o <= '0;
    else if (load_i)             addr_o <= start_i;
    else if (step_i && !fixed_i) addr_o <= inc_i ? addr_o + ONE : addr_o - ONE;
  end
endmodule

// File: rtl/dma_blk_counter.sv
module dma_blk_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_o,
  output logic          end_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt_nxt;
  logic          limited;

  assign cnt_nxt = cnt_o + ONE;
  // zero and all-ones lengths mean unlimited; len+1 cannot overflow otherwise
  assign limited = (len_i != '0) && (len_i != '1);
  assign end_o   = (cnt_nxt == '0) || (limited && (cnt_nxt > len_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_nxt;
  end
endmodule

// File: rtl/dma_irq_vec.sv
module dma_irq_vec
  import dma_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          int_en_i,
  input  logic [7:0]    int_ctl_i,
  input  logic          match_i,
  input  logic          eob_i,
  input  logic [VW-1:0] base_i,
  output logic          req_o,
  output logic [VW-1:0] vec_o
);
  localparam logic [VW-1:0] CAUSE_MATCH = VW'(2);
  localparam logic [VW-1:0] CAUSE_EOB   = VW'(4);
  localparam logic [VW-1:0] CAUSE_MASK  = ~VW'(6);

  logic [VW-1:0] cause;

  always_comb begin
    cause = '0;
    if (int_en_i) begin
      if (int_ctl_i[ICTL_MATCH] && match_i)  cause = CAUSE_MATCH;
      else if (int_ctl_i[ICTL_EOB] && eob_i) cause = CAUSE_EOB;
    end
  end

  assign req_o = (cause != '0);
  assign vec_o = int_ctl_i[ICTL_VSTAT] ? ((base_i & CAUSE_MASK) + cause) : base_i;
endmodule

// File: rtl/dma_search_engine.sv
module dma_search_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          enable_i,
  input  logic [1:0]    cmd_i,
  input  logic [1:0]    mode_i,
  input  logic          a_is_src_i,
  input  logic [7:0]    ctl_a_i,
  input  logic [7:0]    ctl_b_i,
  input  logic [AW-1:0] start_a_i,
  input  logic [AW-1:0] start_b_i,
  input  logic [CW-1:0] length_i,
  input  logic [DW-1:0] match_i,
  input  logic [DW-1:0] mask_i,
  input  logic          ready_i,
  input  logic          rdy_pol_i,
  input  logic          int_en_i,
  input  logic [7:0]    int_ctl_i,
  input  logic [7:0]    vec_base_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_io_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [CW-1:0] byte_cnt_o,
  output logic          eob_o,
  output logic          match_o,
  output logic          irq_o,
  output logic [7:0]    irq_vec_o,
  output logic          busy_o
);
  localparam int NPORT = 2;

  dma_state_e state_q, state_d;
  logic [DW-1:0] data_q;
  logic          eob_q, match_q, stop_q;
  logic          irq_q;
  logic [7:0]    vec_q;

  logic [NPORT-1:0][AW-1:0] port_addr;
  logic [NPORT-1:0][AW-1:0] port_start;
  logic [NPORT-1:0][7:0]    port_ctl;
  logic                     src_sel, dst_sel;
  logic                     step_en;

  logic rdy_match, rdy_ok, go, search_on, hit, stop_now;
  logic cnt_end, cnt_inc;
  logic svc_done, irq_req;
  logic [7:0] irq_vec;

  assign port_start[0] = start_a_i;
  assign port_start[1] = start_b_i;
  assign port_ctl[0]   = ctl_a_i;
  assign port_ctl[1]   = ctl_b_i;
  assign src_sel       = ~a_is_src_i;
  assign dst_sel       = a_is_src_i;

  assign search_on = cmd_i[CMD_SEARCH];
  assign rdy_match = (ready_i == rdy_pol_i);
  assign rdy_ok    = rdy_match || (mode_i == MODE_FREE);
  assign go        = (|cmd_i) && enable_i && !eob_q && !(search_on && match_q)
                     && rdy_ok && !load_i;
  assign hit       = (((data_q ^ match_i) & ~mask_i) == '0);
  assign stop_now  = (mode_i != MODE_FREE) && !rdy_match;
  assign step_en   = (state_q == ST_UPDATE) && !stop_now;
  assign cnt_inc   = (state_q == ST_UPDATE);
  assign svc_done  = (mode_i == MODE_SINGLE) || eob_q || (search_on && match_q) || stop_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dma_port_addr #(.AW(AW)) u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .start_i (port_start[p]),
      .step_i  (step_en),
      .fixed_i (port_ctl[p][CTL_FIX]),
      .inc_i   (port_ctl[p][CTL_INC]),
      .addr_o  (port_addr[p])
    );
  end

  dma_blk_counter #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .inc_i  (cnt_inc),
    .len_i  (length_i),
    .cnt_o  (byte_cnt_o),
    .end_o  (cnt_end)
  );

  dma_irq_vec #(.VW(8)) u_irq (
    .int_en_i  (int_en_i),
    .int_ctl_i (int_ctl_i),
    .match_i   (match_q),
    .eob_i     (eob_q),
    .base_i    (vec_base_i),
    .req_o     (irq_req),
    .vec_o     (irq_vec)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go) state_d = ST_READ;
      ST_READ:   if (bus_ack_i) state_d = cmd_i[CMD_XFER] ? ST_WRITE : ST_UPDATE;
      ST_WRITE:  if (bus_ack_i) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_CHECK;
      ST_CHECK:  state_d = svc_done ? ST_IDLE : ST_READ;
      default:   state_d = ST_IDLE;
    endcase
    if (load_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      eob_q   <= 1'b0;
      match_q <= 1'b0;
      stop_q  <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= 1'b0;
      if (load_i) begin
        eob_q   <= 1'b0;
        match_q <= 1'b0;
        stop_q  <= 1'b0;
      end else begin
        if (state_q == ST_READ && bus_ack_i) data_q <= bus_rdata_i;
        if (state_q == ST_UPDATE) begin
          stop_q  <= stop_now;
          eob_q   <= eob_q | cnt_end;
          match_q <= match_q | (search_on & hit);
        end
        if (state_q == ST_CHECK && svc_done) begin
          irq_q <= irq_req;
          if (irq_req) vec_q <= irq_vec;
        end
      end
    end
  end

  assign bus_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we_o    = (state_q == ST_WRITE);
  assign bus_addr_o  = bus_we_o ? port_addr[dst_sel] : port_addr[src_sel];
  assign bus_io_o    = bus_we_o ? port_ctl[dst_sel][CTL_IO] : port_ctl[src_sel][CTL_IO];
  assign bus_wdata_o = data_q;

  assign addr_a_o  = port_addr[0];
  assign addr_b_o  = port_addr[1];
  assign eob_o     = eob_q;
  assign match_o   = match_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
  assign busy_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_search_engine_chk.sv
module dma_search_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [1:0]    cmd_i,
  input logic          int_en_i,
  input logic [7:0]    int_ctl_i,
  input logic [7:0]    vec_base_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_io_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_ack_i,
  input logic [CW-1:0] byte_cnt_o,
  input logic          eob_o,
  input logic          match_o,
  input logic          irq_o,
  input logic [7:0]    irq_vec_o,
  input logic          busy_o
);
  assert_idle_no_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_i == 2'b00) |=> !bus_req_o);

  assert_write_needs_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> cmd_i[0]);

  assert_match_needs_search_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> cmd_i[1]);

  assert_eob_with_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eob_o) |-> (byte_cnt_o != $past(byte_cnt_o)));

  assert_irq_enabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_en_i);

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_plain_vector_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !int_ctl_i[5]) |-> (irq_vec_o == vec_base_i));

  assert_load_clears_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (byte_cnt_o == '0 && !eob_o && !match_o));

  assert_req_stable_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !load_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_io_o)));
endmodule

bind dma_search_engine dma_search_engine_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/dma_search_engine_tb_top.sv
module dma_search_engine_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        load_i = 0, enable_i = 0, a_is_src_i = 1, ready_i = 1, rdy_pol_i = 1;
  logic [1:0]  cmd_i = 0, mode_i = 0;
  logic [7:0]  ctl_a_i = 0, ctl_b_i = 0, match_i = 0, mask_i = 0;
  logic [15:0] start_a_i = 0, start_b_i = 0, length_i = 0;
  logic        int_en_i = 0;
  logic [7:0]  int_ctl_i = 0, vec_base_i = 0;
  logic        bus_req_o, bus_we_o, bus_io_o, bus_ack_i;
  logic [15:0] bus_addr_o, addr_a_o, addr_b_o, byte_cnt_o;
  logic [7:0]  bus_wdata_o, bus_rdata_i, irq_vec_o;
  logic        eob_o, match_o, irq_o, busy_o;

  dma_search_engine dut_i (.*);

  int vectors = 0, miscompares = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bus slave
  logic [7:0] mem [256];
  logic [7:0] io  [256];
  assign bus_rdata_i = bus_io_o ? io[bus_addr_o[7:0]] : mem[bus_addr_o[7:0]];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_ack_i <= 1'b0;
    else begin
      if (bus_req_o && bus_ack_i && bus_we_o) begin
        if (bus_io_o) io[bus_addr_o[7:0]] <= bus_wdata_o;
        else          mem[bus_addr_o[7:0]] <= bus_wdata_o;
      end
      bus_ack_i <= bus_req_o && !bus_ack_i;
    end
  end

  typedef struct packed { logic [15:0] a; logic we; logic io; logic [7:0] d; } acc_t;
  acc_t     exp_acc [$];
  logic [7:0] exp_irq [$];
  int       drop_n = 0, rd_seen = 0;

  // reference model state
  logic [15:0] m_a, m_b, m_cnt;
  logic        m_eob, m_match;
  logic [7:0]  mm [256];
  logic [7:0]  mi [256];

  always @(negedge clk_i) begin
    if (rst_ni && bus_req_o && bus_ack_i) begin
      if (exp_acc.size() == 0) chk("R14 unexpected access", {bus_we_o, bus_addr_o}, 32'hFFFF_FFFF);
      else begin
        acc_t e;
        e = exp_acc.pop_front();
        chk("R5 R6 access address", bus_addr_o, e.a);
        chk("R7 access direction", bus_we_o, e.we);
        chk("R6 access space", bus_io_o, e.io);
        if (e.we) chk("R7 write data", bus_wdata_o, e.d);
      end
      if (!bus_we_o) begin
        rd_seen++;
        if (drop_n != 0 && rd_seen == drop_n) ready_i = !rdy_pol_i;
      end
    end
    if (rst_ni && irq_o) begin
      if (exp_irq.size() == 0) chk("R11 unexpected irq", irq_vec_o, 32'hFFFF_FFFF);
      else chk("R11 R12 irq vector", irq_vec_o, exp_irq.pop_front());
    end
  end

  function automatic logic [7:0] rd(input logic [15:0] ad, input logic sp);
    return sp ? mi[ad[7:0]] : mm[ad[7:0]];
  endfunction

  task automatic model_run();
    logic rdy; int reads; logic [7:0] cs, cd;
    rdy = ready_i; reads = 0;
    for (int i = 0; i < 256; i++) begin mm[i] = mem[i]; mi[i] = io[i]; end
    cs = a_is_src_i ? ctl_a_i : ctl_b_i;
    cd = a_is_src_i ? ctl_b_i : ctl_a_i;
    while (cmd_i != 0 && !m_eob && !(cmd_i[1] && m_match) && (mode_i == 1 || rdy == rdy_pol_i)) begin
      logic stop, more;
      more = 1'b1;
      while (more) begin
        logic [15:0] sa, da; logic [7:0] d; logic [7:0] cause;
        sa = a_is_src_i ? m_a : m_b;
        da = a_is_src_i ? m_b : m_a;
        d = rd(sa, cs[3]);
        exp_acc.push_back('{a: sa, we: 1'b0, io: cs[3], d: d});
        reads++;
        if (drop_n != 0 && reads == drop_n) rdy = !rdy_pol_i;
        if (cmd_i[0]) begin
          exp_acc.push_back('{a: da, we: 1'b1, io: cd[3], d: d});
          if (cd[3]) mi[da[7:0]] = d; else mm[da[7:0]] = d;
        end
        if (cmd_i[1] && (((d ^ match_i) & ~mask_i) == 0)) m_match = 1;
        stop = (mode_i != 1) && (rdy != rdy_pol_i);
        if (!stop) begin
          if (!ctl_a_i[5]) m_a = ctl_a_i[4] ? m_a + 1 : m_a - 1;
          if (!ctl_b_i[5]) m_b = ctl_b_i[4] ? m_b + 1 : m_b - 1;
        end
        m_cnt++;
        if (m_cnt == 0 || (length_i != 0 && length_i != 16'hFFFF && int'(m_cnt) >= int'(length_i) + 1))
          m_eob = 1;
        more = (mode_i != 0) && !m_eob && !(cmd_i[1] && m_match) && !stop;
        if (!more && int_en_i) begin
          cause = 0;
          if (int_ctl_i[0] && m_match) cause = 2;
          else if (int_ctl_i[1] && m_eob) cause = 4;
          if (cause != 0) exp_irq.push_back(int_ctl_i[5] ? (vec_base_i & 8'hF9) + cause : vec_base_i);
        end
      end
    end
  endtask

  task automatic do_load();
    @(negedge clk_i) load_i = 1;
    @(negedge clk_i) load_i = 0;
    m_a = start_a_i; m_b = start_b_i; m_cnt = 0; m_eob = 0; m_match = 0;
  endtask

  task automatic run(input string req);
    int idle;
    rd_seen = 0;
    model_run();
    @(negedge clk_i) enable_i = 1;
    idle = 0;
    while (idle < 6) begin
      @(negedge clk_i);
      idle = busy_o ? 0 : idle + 1;
    end
    enable_i = 0;
    drop_n = 0;
    chk({req, " addr A"}, addr_a_o, m_a);
    chk({req, " addr B"}, addr_b_o, m_b);
    chk({req, " count R10"}, byte_cnt_o, m_cnt);
    chk({req, " eob R10"}, eob_o, m_eob);
    chk({req, " match R8"}, match_o, m_match);
    chk({req, " accesses left"}, exp_acc.size(), 0);
    chk({req, " irqs left R11"}, exp_irq.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i); cyc++;
      if (cyc > 150000) begin
        miscompares++; vectors++;
        $display("FAIL watchdog: got %0d expected <150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); io[i] = 8'(i) ^ 8'hA5; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("reset bus_req", bus_req_o, 0);
    chk("reset count R10", byte_cnt_o, 0);
    chk("reset flags", {eob_o, match_o, irq_o}, 0);

    // R1: no command
    start_a_i = 16'h0010; start_b_i = 16'h0080; ctl_a_i = 8'h10; ctl_b_i = 8'h08;
    length_i = 4; mode_i = 2; cmd_i = 2'b00;
    do_load();
    run("R1 idle command");

    // R4 R5 R6 R7: burst transfer, A mem inc -> B io dec, length 4
    cmd_i = 2'b01;
    do_load();
    run("R4 burst transfer");
    // R2: end of block already set blocks start
    run("R2 eob blocks start");

    // R3 R4 R12: single mode, B -> A fixed io, active-low ready
    a_is_src_i = 0; ctl_b_i = 8'h10; ctl_a_i = 8'h28; start_b_i = 16'h0040; start_a_i = 16'h0090;
    length_i = 2; mode_i = 0; rdy_pol_i = 0; ready_i = 0;
    int_en_i = 1; int_ctl_i = 8'h22; vec_base_i = 8'h3F;
    do_load();
    run("R3 R12 single byte services");

    // R8 R3 R11: search only, mode 1 with ready inactive, match on third byte
    a_is_src_i = 1; ctl_a_i = 8'h10; start_a_i = 16'h0020; length_i = 0;
    cmd_i = 2'b10; mode_i = 1; rdy_pol_i = 1; ready_i = 0;
    mask_i = 8'h0F; match_i = mem[8'h22] ^ 8'h05;
    int_ctl_i = 8'h03; vec_base_i = 8'h50;
    do_load();
    run("R8 search match");
    run("R2 match blocks start");

    // R13: load clears flags
    do_load();
    chk("R13 load clears count", byte_cnt_o, 0);
    chk("R13 load clears flags", {eob_o, match_o}, 0);
    chk("R13 load sets addr A", addr_a_o, 16'h0020);

    // R3: mode 2 with ready inactive does nothing
    cmd_i = 2'b01; mode_i = 2; ready_i = 0;
    run("R3 ready gates start");

    // R9 R10: ready drop after third read, length FFFF unlimited
    ready_i = 1; start_a_i = 16'h0060; start_b_i = 16'h00C0; ctl_a_i = 8'h10; ctl_b_i = 8'h00;
    length_i = 16'hFFFF; int_ctl_i = 8'h22; vec_base_i = 8'h80; drop_n = 3;
    do_load();
    run("R9 ready drop mid burst");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule